// File: doc/BRIEF.md
# Interrupt Controller Command Port

This block is the programming front end of an eight-line priority interrupt controller. A host writes and reads bytes through a two-address strobe interface. The block sorts each write into one of four kinds: an initialisation start, a mode command, a coded operation on the in-service set, or a data word. It walks the multi-word initialisation sequence and holds the resulting configuration: vector base, nesting and auto-acknowledge flags, mask, rotation base and readback selection. These configuration values feed a separate priority resolver.

The resolver owns the request and in-service bit sets. This port receives copies of both. It returns single-cycle clear vectors for them, and an initialisation pulse that tells the resolver to drop its state and lower its interrupt output. For a non-specific end-of-interrupt, the port finds the highest-priority in-service line itself, scanning upward from the rotation base. Poll mode turns the next read into an acknowledge: the read returns the line the resolver reports as pending and clears that line.

Top module: `icp_cmd_port`

## Requirements
- R1: A write to address 0 with data bit 4 set pulses `init_pulse` in that cycle. After the clock edge, the mask, rotation base, vector base, nesting flag, auto-acknowledge flag, rotate-on-auto flag, special-mask flag, readback select and poll flag are all zero. Data bit 0 records whether a fourth word will follow, and data bit 1 records single (non-cascaded) mode, shown on `single_mode`.
- R2: In the sequence, the first address-1 word loads `vec_base` with the data's low three bits forced to zero. The sequence then expects a cascade word if not single, otherwise the fourth word if one was announced, otherwise it ends. After a cascade word it expects the fourth word if one was announced, otherwise it ends. Sequence words never load the mask.
- R3: The fourth word sets `nested_mode` from data bit 4 and `auto_eoi` from data bit 1, and ends the sequence.
- R4: A write to address 0 with bit 4 clear and bit 3 set is a mode command. Bit 2 arms poll. With bit 1 set, bit 0 selects in-service (1) or request (0) readback, and with bit 1 clear the selection is kept. With bit 6 set, `spec_mask` takes bit 5, and with bit 6 clear it is kept.
- R5: A write to address 0 with bits 4 and 3 clear is an operation with code data[7:5]. Codes 0 and 4 set `rot_auto_eoi` to bit 7. Code 2 changes nothing and clears nothing.
- R6: Code 1 clears, through `svc_clr`, the in-service line found first when scanning `svc_bits` upward from `prio_base` modulo 8. Nothing is cleared when `svc_bits` is zero. Code 5 does the same and, if a line was found, sets `prio_base` to that line plus 1 modulo 8.
- R7: Code 3 clears in-service line data[2:0]. Code 7 clears that line and sets `prio_base` to data[2:0] plus 1 modulo 8. Code 6 sets `prio_base` to data[2:0] plus 1 modulo 8 without clearing anything.
- R8: A write to address 1 outside the sequence loads `irq_mask` with the data.
- R9: With poll armed, a read at either address disarms poll. If `pend_vld` is high, it returns `pend_line` and pulses bit `pend_line` of both `svc_clr` and `req_clr`. Otherwise it returns 7 and clears nothing.
- R10: A read without poll returns `svc_bits` or `req_bits` at address 0 (by readback select), or `irq_mask` at address 1, on `rdata` in the cycle after the strobe. `rdata` holds between reads.
- R11: When a read and a write share a cycle, the read returns the values from before the write. Clears from a polled read and from an operation in the same cycle appear together in `svc_clr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | 1 | Write strobe, one cycle per byte |
| rd_stb | input | 1 | Read strobe, one cycle per byte |
| addr | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| req_bits | input | 8 | Request set from the resolver |
| svc_bits | input | 8 | In-service set from the resolver |
| pend_vld | input | 1 | Resolver has a line to deliver |
| pend_line | input | 3 | Line the resolver would deliver |
| rdata | output | 8 | Registered read data |
| svc_clr | output | 8 | In-service clear vector, this cycle |
| req_clr | output | 8 | Request clear vector, this cycle |
| init_pulse | output | 1 | Initialisation start, this cycle |
| irq_mask | output | 8 | Line mask |
| vec_base | output | 8 | Vector base, low bits zero |
| prio_base | output | 3 | Line holding top priority |
| auto_eoi | output | 1 | Auto-acknowledge mode |
| rot_auto_eoi | output | 1 | Rotate on auto-acknowledge |
| nested_mode | output | 1 | Special fully nested mode |
| spec_mask | output | 1 | Special mask mode |
| single_mode | output | 1 | Non-cascaded configuration |

## Verification
A polled read and an operation write can land in the same cycle. Both produce in-service clears, and the read must see the state from before the write. The bench arms poll, then asserts both strobes together with a specific end-of-interrupt for one line while the resolver reports another line pending. It expects both bits in `svc_clr`, only the polled bit in `req_clr`, and the polled line on `rdata` one cycle later. A second case reads the mask in the same cycle it is rewritten and expects the old mask back while the port shows the new one.

// File: rtl/icp_pkg.sv
package icp_pkg;
   typedef enum logic [1:0] {
      SEQ_IDLE = 2'd0,
      SEQ_BASE = 2'd1,
      SEQ_CASC = 2'd2,
      SEQ_MODE = 2'd3
   } seq_t;

   localparam logic [2:0] OP_ROT_OFF  = 3'd0;
   localparam logic [2:0] OP_EOI      = 3'd1;
   localparam logic [2:0] OP_NOP      = 3'd2;
   localparam logic [2:0] OP_SEOI     = 3'd3;
   localparam logic [2:0] OP_ROT_ON   = 3'd4;
   localparam logic [2:0] OP_EOI_ROT  = 3'd5;
   localparam logic [2:0] OP_SET_BASE = 3'd6;
   localparam logic [2:0] OP_SEOI_ROT = 3'd7;

   localparam logic [7:0] POLL_EMPTY = 8'h07;
endpackage

// File: rtl/icp_rot_pick.sv
module icp_rot_pick #(
   parameter int N = 8
) (
   input  logic [N-1:0]         bits,
   input  logic [$clog2(N)-1:0] start,
   output logic                 found,
   output logic [$clog2(N)-1:0] line
);
   localparam int IW = $clog2(N);

   logic [2*N-1:0] dbl;
   logic [N-1:0]   rot;

   generate
      if ((1 << IW) != N) begin : g_bad_n
         $error("icp_rot_pick: N must be a power of two");
      end
   endgenerate

   always_comb begin
      dbl   = {bits, bits};
      rot   = dbl[start +: N];
      found = |bits;
      line  = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (rot[i]) line = start + IW'(i);
      end
   end
endmodule

// File: rtl/icp_init_seq.sv
module icp_init_seq import icp_pkg::*; #(
   parameter int DW       = 8,
   parameter int BASE_LSB = 3
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start,
   input  logic          data_wr,
   input  logic [DW-1:0] wdata,
   output seq_t          state,
   output logic [DW-1:0] vec_base,
   output logic          nested,
   output logic          aeoi,
   output logic          single
);
   localparam logic [DW-1:0] BASE_KEEP = {DW{1'b1}} << BASE_LSB;

   logic fourth_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= SEQ_IDLE;
         vec_base <= '0;
         nested   <= 1'b0;
         aeoi     <= 1'b0;
         single   <= 1'b0;
         fourth_q <= 1'b0;
      end else if (start) begin
         state    <= SEQ_BASE;
         fourth_q <= wdata[0];
         single   <= wdata[1];
         vec_base <= '0;
         nested   <= 1'b0;
         aeoi     <= 1'b0;
      end else if (data_wr) begin
         case (state)
            SEQ_BASE: begin
               vec_base <= wdata & BASE_KEEP;
               state    <= !single ? SEQ_CASC : (fourth_q ? SEQ_MODE : SEQ_IDLE);
            end
            SEQ_CASC: state <= fourth_q ? SEQ_MODE : SEQ_IDLE;
            SEQ_MODE: begin
               nested <= wdata[4];
               aeoi   <= wdata[1];
               state  <= SEQ_IDLE;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/icp_cmd_port.sv
module icp_cmd_port import icp_pkg::*; #(
   parameter int LINES = 8,
   parameter int DW    = 8
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_stb,
   input  logic                     rd_stb,
   input  logic                     addr,
   input  logic [DW-1:0]            wdata,
   input  logic [LINES-1:0]         req_bits,
   input  logic [LINES-1:0]         svc_bits,
   input  logic                     pend_vld,
   input  logic [$clog2(LINES)-1:0] pend_line,
   output logic [DW-1:0]            rdata,
   output logic [LINES-1:0]         svc_clr,
   output logic [LINES-1:0]         req_clr,
   output logic                     init_pulse,
   output logic [LINES-1:0]         irq_mask,
   output logic [DW-1:0]            vec_base,
   output logic [$clog2(LINES)-1:0] prio_base,
   output logic                     auto_eoi,
   output logic                     rot_auto_eoi,
   output logic                     nested_mode,
   output logic                     spec_mask,
   output logic                     single_mode
);
   localparam int LW = $clog2(LINES);

   generate
      if (LINES != 8 || DW != 8) begin : g_bad_cfg
         $error("icp_cmd_port: command encoding needs LINES == 8 and DW == 8");
      end
   endgenerate

   seq_t           seq_state;
   logic           poll_q, rdsel_q;
   logic           is_init, is_mode, is_op, data_wr, mask_wr, poll_take;
   logic [2:0]     op;
   logic           pk_found;
   logic [LW-1:0]  pk_line;
   logic [LW-1:0]  base_nx;
   logic           rot_nx;
   logic [LINES-1:0] op_clr, poll_clr;
   logic [DW-1:0]  rd_val;

   assign is_init  = wr_stb && !addr && wdata[4];
   assign is_mode  = wr_stb && !addr && !wdata[4] && wdata[3];
   assign is_op    = wr_stb && !addr && !wdata[4] && !wdata[3];
   assign data_wr  = wr_stb && addr;
   assign mask_wr  = data_wr && (seq_state == SEQ_IDLE);
   assign op       = wdata[7:5];
   assign poll_take = rd_stb && poll_q && pend_vld;

   icp_init_seq #(.DW(DW), .BASE_LSB(LW)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (is_init),
      .data_wr  (data_wr),
      .wdata    (wdata),
      .state    (seq_state),
      .vec_base (vec_base),
      .nested   (nested_mode),
      .aeoi     (auto_eoi),
      .single   (single_mode)
   );

   icp_rot_pick #(.N(LINES)) u_pick (
      .bits  (svc_bits),
      .start (prio_base),
      .found (pk_found),
      .line  (pk_line)
   );

   always_comb begin
      op_clr  = '0;
      base_nx = prio_base;
      rot_nx  = rot_auto_eoi;
      if (is_op) begin
         case (op)
            OP_ROT_OFF, OP_ROT_ON: rot_nx = wdata[7];
            OP_EOI, OP_EOI_ROT: begin
               if (pk_found) begin
                  op_clr[pk_line] = 1'b1;
                  if (op == OP_EOI_ROT) base_nx = pk_line + LW'(1);
               end
            end
            OP_SEOI: op_clr[wdata[LW-1:0]] = 1'b1;
            OP_SET_BASE: base_nx = wdata[LW-1:0] + LW'(1);
            OP_SEOI_ROT: begin
               op_clr[wdata[LW-1:0]] = 1'b1;
               base_nx = wdata[LW-1:0] + LW'(1);
            end
            default: ;
         endcase
      end
   end

   always_comb begin
      poll_clr = '0;
      if (poll_take) poll_clr[pend_line] = 1'b1;
   end

   assign svc_clr    = op_clr | poll_clr;
   assign req_clr    = poll_clr;
   assign init_pulse = is_init;

   always_comb begin
      if (poll_q)       rd_val = pend_vld ? DW'(pend_line) : POLL_EMPTY;
      else if (addr)    rd_val = irq_mask;
      else if (rdsel_q) rd_val = svc_bits;
      else              rd_val = req_bits;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_mask     <= '0;
         prio_base    <= '0;
         rot_auto_eoi <= 1'b0;
         spec_mask    <= 1'b0;
         rdsel_q      <= 1'b0;
         poll_q       <= 1'b0;
         rdata        <= '0;
      end else begin
         if (rd_stb) rdata <= rd_val;
         if (is_init) begin
            irq_mask     <= '0;
            prio_base    <= '0;
            rot_auto_eoi <= 1'b0;
            spec_mask    <= 1'b0;
            rdsel_q      <= 1'b0;
            poll_q       <= 1'b0;
         end else begin
            prio_base    <= base_nx;
            rot_auto_eoi <= rot_nx;
            if (mask_wr) irq_mask <= wdata;
            if (is_mode && wdata[2])      poll_q <= 1'b1;
            else if (rd_stb)              poll_q <= 1'b0;
            if (is_mode && wdata[1])      rdsel_q <= wdata[0];
            if (is_mode && wdata[6])      spec_mask <= wdata[5];
         end
      end
   end
endmodule

// File: rtl/icp_cmd_port_chk.sv
module icp_cmd_port_chk import icp_pkg::*; (
   input logic       clk,
   input logic       rst_n,
   input logic       wr_stb,
   input logic       rd_stb,
   input logic       addr,
   input logic [7:0] wdata,
   input logic [7:0] svc_bits,
   input logic       pend_vld,
   input logic [7:0] rdata,
   input logic [7:0] svc_clr,
   input logic [7:0] req_clr,
   input logic [7:0] irq_mask,
   input logic [7:0] vec_base,
   input logic [2:0] prio_base,
   input logic       auto_eoi,
   input logic       poll_q,
   input seq_t       seq_state
);
   p_init_clears_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !addr && wdata[4]) |=> (irq_mask == 8'h00 && prio_base == 3'd0 &&
                                         vec_base == 8'h00 && !auto_eoi && !poll_q));

   p_base_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr && seq_state == SEQ_BASE) |=> (vec_base == ($past(wdata) & 8'hF8)));

   p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && addr && seq_state == SEQ_IDLE) |=> (irq_mask == $past(wdata)));

   p_eoi_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_stb && !addr && wdata[7:3] == 5'b00100 && svc_bits != 8'h00 && !rd_stb)
      |-> ($countones(svc_clr) == 1 && (svc_clr & ~svc_bits) == 8'h00));

   p_poll_empty_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && poll_q && !pend_vld) |=> (rdata == POLL_EMPTY));

   p_poll_disarm_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !wr_stb) |=> !poll_q);

   p_req_clr_src_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_clr != 8'h00) |-> (rd_stb && poll_q && $onehot0(req_clr)));

   p_read_mask_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_stb && !poll_q && addr) |=> (rdata == $past(irq_mask)));

   p_clr_pair_r11: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(svc_clr) <= 2);
endmodule

bind icp_cmd_port icp_cmd_port_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .wr_stb    (wr_stb),
   .rd_stb    (rd_stb),
   .addr      (addr),
   .wdata     (wdata),
   .svc_bits  (svc_bits),
   .pend_vld  (pend_vld),
   .rdata     (rdata),
   .svc_clr   (svc_clr),
   .req_clr   (req_clr),
   .irq_mask  (irq_mask),
   .vec_base  (vec_base),
   .prio_base (prio_base),
   .auto_eoi  (auto_eoi),
   .poll_q    (poll_q),
   .seq_state (seq_state)
);

// File: tb/icp_cmd_port_tb.sv
module icp_cmd_port_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       wr_stb = 1'b0, rd_stb = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0, req_bits = '0, svc_bits = '0;
   logic       pend_vld = 1'b0;
   logic [2:0] pend_line = '0;
   logic [7:0] rdata, svc_clr, req_clr, irq_mask, vec_base;
   logic [2:0] prio_base;
   logic       init_pulse, auto_eoi, rot_auto_eoi, nested_mode, spec_mask, single_mode;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   icp_cmd_port u_dut (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb), .addr(addr),
      .wdata(wdata), .req_bits(req_bits), .svc_bits(svc_bits), .pend_vld(pend_vld),
      .pend_line(pend_line), .rdata(rdata), .svc_clr(svc_clr), .req_clr(req_clr),
      .init_pulse(init_pulse), .irq_mask(irq_mask), .vec_base(vec_base),
      .prio_base(prio_base), .auto_eoi(auto_eoi), .rot_auto_eoi(rot_auto_eoi),
      .nested_mode(nested_mode), .spec_mask(spec_mask), .single_mode(single_mode)
   );

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s act=%0h exp=%0h", req, act, exp);
      end
   endtask

   task automatic put(logic w, logic r, logic a, logic [7:0] d);
      @(negedge clk);
      wr_stb = w; rd_stb = r; addr = a; wdata = d;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      wr_stb = 1'b0; rd_stb = 1'b0;
      #1;
   endtask

   task automatic set_base(int b);
      put(1'b1, 1'b0, 1'b0, 8'hC0 | 8'((b + 7) & 7));
      idle();
   endtask

   function automatic int first_from(logic [7:0] bits, int b);
      for (int i = 0; i < 8; i++)
         if (bits[(b + i) % 8]) return (b + i) % 8;
      return -1;
   endfunction

   initial begin
      #1_000_000;
      errors++;
      checks++;
      $display("FAIL R11 watchdog act=running exp=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 / R10: reset state
      chk("R1 reset mask", irq_mask, 0);
      chk("R1 reset base", prio_base, 0);
      chk("R1 reset vec", vec_base, 0);
      chk("R10 reset rdata", rdata, 0);
      chk("R1 reset flags", {auto_eoi, rot_auto_eoi, nested_mode, spec_mask, single_mode}, 0);

      // R8: mask sweep with readback at address 1 (R10)
      for (int m = 0; m < 256; m++) begin
         put(1'b1, 1'b0, 1'b1, 8'(m));
         idle();
         chk("R8 mask port", irq_mask, m);
         put(1'b0, 1'b1, 1'b1, 8'h00);
         idle();
         chk("R10 mask read", rdata, m);
      end

      // R1, R2, R3: every single/fourth combination
      for (int k = 0; k < 4; k++) begin
         logic sgl, fw;
         sgl = k[1]; fw = k[0];
         put(1'b1, 1'b0, 1'b1, 8'hA5); idle();
         set_base(5);
         put(1'b1, 1'b0, 1'b0, 8'h10 | {6'd0, sgl, fw});
         chk("R1 init pulse", init_pulse, 1);
         idle();
         chk("R1 mask cleared", irq_mask, 0);
         chk("R1 base cleared", prio_base, 0);
         chk("R1 single", single_mode, sgl);
         put(1'b1, 1'b0, 1'b1, 8'h8F); idle();
         chk("R2 vector base", vec_base, 8'h88);
         chk("R2 mask untouched", irq_mask, 0);
         if (!sgl) begin
            put(1'b1, 1'b0, 1'b1, 8'h04); idle();
            chk("R2 cascade word no mask", irq_mask, 0);
         end
         if (fw) begin
            put(1'b1, 1'b0, 1'b1, 8'h12); idle();
            chk("R3 nested", nested_mode, 1);
            chk("R3 auto eoi", auto_eoi, 1);
            chk("R3 mask untouched", irq_mask, 0);
         end else begin
            chk("R3 nested off", nested_mode, 0);
         end
         put(1'b1, 1'b0, 1'b1, 8'h3C); idle();
         chk("R2 sequence ended, mask loads", irq_mask, 8'h3C);
      end

      // R4: readback select and special mask
      req_bits = 8'h42; svc_bits = 8'h81;
      put(1'b1, 1'b0, 1'b0, 8'h0B); idle();
      put(1'b0, 1'b1, 1'b0, 8'h00); idle();
      chk("R4 select in-service", rdata, 8'h81);
      put(1'b1, 1'b0, 1'b0, 8'h09); idle();
      put(1'b0, 1'b1, 1'b0, 8'h00); idle();
      chk("R4 select kept", rdata, 8'h81);
      put(1'b1, 1'b0, 1'b0, 8'h0A); idle();
      put(1'b0, 1'b1, 1'b0, 8'h00); idle();
      chk("R4 select request", rdata, 8'h42);
      put(1'b1, 1'b0, 1'b0, 8'h68); idle();
      chk("R4 special mask on", spec_mask, 1);
      put(1'b1, 1'b0, 1'b0, 8'h28); idle();
      chk("R4 special mask kept", spec_mask, 1);
      put(1'b1, 1'b0, 1'b0, 8'h48); idle();
      chk("R4 special mask off", spec_mask, 0);

      // R5: rotate flag and no-op
      put(1'b1, 1'b0, 1'b0, 8'h80); idle();
      chk("R5 rotate on", rot_auto_eoi, 1);
      put(1'b1, 1'b0, 1'b0, 8'h00); idle();
      chk("R5 rotate off", rot_auto_eoi, 0);
      set_base(3);
      svc_bits = 8'hFF;
      put(1'b1, 1'b0, 1'b0, 8'h47);
      chk("R5 no-op clears nothing", svc_clr, 0);
      idle();
      chk("R5 no-op base kept", prio_base, 3);

      // R6 and R7 (code 6): exhaustive non-specific EOI sweep
      for (int b = 0; b < 8; b++) begin
         set_base(b);
         chk("R7 set base", prio_base, b);
         for (int s = 0; s < 256; s++) begin
            int p;
            p = first_from(8'(s), b);
            svc_bits = 8'(s);
            put(1'b1, 1'b0, 1'b0, 8'h20);
            chk("R6 eoi clear", svc_clr, (p < 0) ? 0 : (1 << p));
            idle();
            chk("R6 eoi base kept", prio_base, b);
         end
         for (int s = 0; s < 256; s++) begin
            int p;
            p = first_from(8'(s), b);
            set_base(b);
            svc_bits = 8'(s);
            put(1'b1, 1'b0, 1'b0, 8'hA0);
            chk("R6 rotating eoi clear", svc_clr, (p < 0) ? 0 : (1 << p));
            idle();
            chk("R6 rotating eoi base", prio_base, (p < 0) ? b : (p + 1) % 8);
         end
      end

      // R7: specific clears
      for (int l = 0; l < 8; l++) begin
         set_base(2);
         svc_bits = 8'h00;
         put(1'b1, 1'b0, 1'b0, 8'h60 | 8'(l));
         chk("R7 specific clear", svc_clr, 1 << l);
         idle();
         chk("R7 specific base kept", prio_base, 2);
         put(1'b1, 1'b0, 1'b0, 8'hE0 | 8'(l));
         chk("R7 specific rotate clear", svc_clr, 1 << l);
         idle();
         chk("R7 specific rotate base", prio_base, (l + 1) % 8);
         put(1'b1, 1'b0, 1'b0, 8'hC0 | 8'(l));
         chk("R7 base set clears nothing", svc_clr, 0);
         idle();
      end

      // R9: polled reads
      put(1'b1, 1'b0, 1'b1, 8'h3C); idle();
      for (int l = 0; l < 8; l++) begin
         pend_vld = 1'b1; pend_line = 3'(l);
         put(1'b1, 1'b0, 1'b0, 8'h0C); idle();
         put(1'b0, 1'b1, l[0], 8'h00);
         chk("R9 poll svc clear", svc_clr, 1 << l);
         chk("R9 poll req clear", req_clr, 1 << l);
         idle();
         chk("R9 poll line", rdata, l);
         put(1'b0, 1'b1, 1'b1, 8'h00);
         chk("R9 disarmed no clear", req_clr, 0);
         idle();
         chk("R9 disarmed reads mask", rdata, 8'h3C);
      end
      pend_vld = 1'b0;
      put(1'b1, 1'b0, 1'b0, 8'h0C); idle();
      put(1'b0, 1'b1, 1'b0, 8'h00);
      chk("R9 empty poll no clear", svc_clr, 0);
      idle();
      chk("R9 empty poll value", rdata, 7);

      // R11: read and write in the same cycle
      pend_vld = 1'b1; pend_line = 3'd3;
      put(1'b1, 1'b0, 1'b0, 8'h0C); idle();
      put(1'b1, 1'b1, 1'b0, 8'h65);
      chk("R11 merged svc clear", svc_clr, 8'h28);
      chk("R11 req clear poll only", req_clr, 8'h08);
      idle();
      chk("R11 polled line", rdata, 3);
      put(1'b1, 1'b1, 1'b1, 8'h99);
      idle();
      chk("R11 read sees old mask", rdata, 8'h3C);
      chk("R11 mask updated", irq_mask, 8'h99);

      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule